// File: doc/BRIEF.md
# Multi-Lane Serial Read Data Shifter

This block is the read-data end of a serial flash target. An upstream single-lane front end captures the read opcode and the address. It then pulses `cmd_load` with the opcode and the current Quad Enable state. From the next falling serial-clock edge onward, this block pulls bytes from a memory-side ready/valid source. It shifts them out on one, two or four I/O lanes, most significant bits first. The falling edges of the serial clock arrive as a one-cycle strobe, `sclk_fall`, in the system clock domain.

The lane count is fixed per command by the opcode:
- Single lane: 03h or 0Bh.
- Two lanes: 3Bh or BBh.
- Four lanes: 6Bh, EBh or E7h.

The four-lane opcodes work only when Quad Enable is set. In four-lane mode, lanes 2 and 3 are the pins that otherwise serve as write-protect and hold. A refused or unknown opcode leaves every lane released until the chip select goes high.

The control is one state machine with these states:
- `ST_IDLE`: deselected or waiting for a command.
- `ST_ARMED`: command accepted, no byte loaded yet.
- `ST_SHIFT`: lanes driven and advancing.
- `ST_STALL`: a byte boundary was reached with no source data, so the lanes are held.
- `ST_REJECT`: unsupported command; lanes released.

The transitions are:
- IDLE→ARMED on `cmd_load` with a supported opcode.
- IDLE→REJECT on `cmd_load` with an unsupported opcode.
- ARMED→SHIFT and STALL→SHIFT when a byte is taken on a falling edge.
- SHIFT→STALL on a boundary edge with the source empty.
- Any state→IDLE when `cs_n` is high.

Top module: `lane_read_shifter`

## Requirements
- R1: After reset, `io_oe`, `io_out` and `underrun` are all zero.
- R2: Opcodes 03h and 0Bh drive only lane 1 (`io_oe`=4'b0010). The lane carries one bit per falling edge, bit 7 first.
- R3: Opcodes 3Bh and BBh drive lanes 0 and 1 (`io_oe`=4'b0011). Each falling edge presents a bit pair in the order {7,6},{5,4},{3,2},{1,0}, with the higher bit on lane 1.
- R4: With Quad Enable set, opcodes 6Bh, EBh and E7h drive all four lanes (`io_oe`=4'b1111). Each falling edge presents nibble [7:4] and then [3:0], with the highest bit of the nibble on lane 3.
- R5: A four-lane opcode with Quad Enable clear, or any other opcode, keeps `io_oe` at zero and `src_ready` low until `cs_n` rises.
- R6: Lanes and enables change only in the cycle after a `sclk_fall` strobe, apart from the release on deselect.
- R7: `src_ready` is high only in a `sclk_fall` cycle at a byte boundary. A new byte is taken every 8, 4 or 2 falling edges in single, dual or quad mode respectively.
- R8: Between `cmd_load` and the first byte taken, all lanes stay released.
- R9: When a boundary falling edge finds `src_valid` low, the lanes hold their last value and stay enabled, and `underrun` is set. `underrun` stays set until `cs_n` rises. Shifting resumes at a later falling edge that finds data.
- R10: `cs_n` high releases all lanes and clears `underrun` on the next clock. A lane that is not enabled outputs 0.
- R11: `cmd_load` is ignored unless the block is idle with `cs_n` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk_fall | input | 1 | One-cycle strobe marking a falling serial-clock edge |
| cmd_load | input | 1 | Pulse: opcode is valid, data phase begins |
| cmd_opcode | input | 8 | Decoded read opcode |
| qe_bit | input | 1 | Quad Enable status bit |
| src_data | input | 8 | Byte from the memory side |
| src_valid | input | 1 | `src_data` is valid |
| src_ready | output | 1 | Byte taken this cycle |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Per-lane output enables |
| underrun | output | 1 | Sticky source-underrun flag |

## Verification
`src_ready` is combinational and is high in the very cycle that carries the `sclk_fall` strobe. The lane values, the enables and `underrun` all update on the clock edge that samples that strobe. A deselect clears the outputs one edge after `cs_n` rises. The bench drives its inputs on falling clock edges and records each strobe and each handshake as it happens at the rising edge. Its monitor then samples the lanes at the following falling edge, where they already show the effect of that edge. The monitor counts a new slice only when the strobe fell mid-byte or was accompanied by a taken byte. This way, stalled boundary edges add no bits to the reassembled byte.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    typedef enum logic [1:0] {
        LM_NONE   = 2'd0,
        LM_SINGLE = 2'd1,
        LM_DUAL   = 2'd2,
        LM_QUAD   = 2'd3
    } lane_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARMED  = 3'd1,
        ST_SHIFT  = 3'd2,
        ST_STALL  = 3'd3,
        ST_REJECT = 3'd4
    } seq_state_e;

endpackage

// File: rtl/lrs_mode_dec.sv
module lrs_mode_dec
    import lrs_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic [OP_W-1:0] opcode,
    input  logic            qe,
    output lane_mode_e      mode
);

    always_comb begin
        mode = LM_NONE;
        case (opcode)
            OP_W'(8'h03), OP_W'(8'h0B):              mode = LM_SINGLE;
            OP_W'(8'h3B), OP_W'(8'hBB):              mode = LM_DUAL;
            OP_W'(8'h6B), OP_W'(8'hEB), OP_W'(8'hE7): mode = qe ? LM_QUAD : LM_NONE;
            default:                                  mode = LM_NONE;
        endcase
    end

endmodule

// File: rtl/lrs_lane_map.sv
module lrs_lane_map
    import lrs_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4
) (
    input  lane_mode_e        mode,
    input  logic              drive,
    input  logic [BYTE_W-1:0] shreg,
    output logic [LANES-1:0]  io_out,
    output logic [LANES-1:0]  io_oe
);

    logic [LANES-1:0] val_raw;
    logic [LANES-1:0] oe_raw;

    always_comb begin
        val_raw = '0;
        oe_raw  = '0;
        case (mode)
            LM_SINGLE: begin
                val_raw[1] = shreg[BYTE_W-1];
                oe_raw[1]  = 1'b1;
            end
            LM_DUAL: begin
                val_raw[1] = shreg[BYTE_W-1];
                val_raw[0] = shreg[BYTE_W-2];
                oe_raw[1:0] = 2'b11;
            end
            LM_QUAD: begin
                for (int i = 0; i < LANES; i++) begin
                    val_raw[i] = shreg[BYTE_W-LANES+i];
                end
                oe_raw = '1;
            end
            default: begin
                val_raw = '0;
                oe_raw  = '0;
            end
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign io_oe[g]  = drive & oe_raw[g];
        assign io_out[g] = drive & oe_raw[g] & val_raw[g];
    end

endmodule

// File: rtl/lrs_seq.sv
module lrs_seq
    import lrs_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk_fall,
    input  logic              cmd_load,
    input  lane_mode_e        dec_mode,
    input  logic [BYTE_W-1:0] src_data,
    input  logic              src_valid,
    output logic              src_ready,
    output seq_state_e        state,
    output lane_mode_e        mode_q,
    output logic [BYTE_W-1:0] shreg,
    output logic              drive,
    output logic              underrun
);

    localparam int CNT_W = $clog2(BYTE_W + 1);

    seq_state_e        nxt;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg_adv;
    logic              at_boundary;
    logic              take;

    function automatic logic [CNT_W-1:0] slices_of(lane_mode_e m);
        case (m)
            LM_QUAD: return CNT_W'(BYTE_W / 4);
            LM_DUAL: return CNT_W'(BYTE_W / 2);
            default: return CNT_W'(BYTE_W);
        endcase
    endfunction

    always_comb begin
        case (mode_q)
            LM_QUAD: shreg_adv = shreg << 4;
            LM_DUAL: shreg_adv = shreg << 2;
            default: shreg_adv = shreg << 1;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        at_boundary = (state == ST_ARMED) || (state == ST_STALL) ||
                      ((state == ST_SHIFT) && (cnt == CNT_W'(1)));
        src_ready   = sclk_fall && !cs_n && at_boundary;
        take        = src_ready && src_valid;
        drive       = (state == ST_SHIFT) || (state == ST_STALL);
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (cs_n) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   if (cmd_load) nxt = (dec_mode == LM_NONE) ? ST_REJECT : ST_ARMED;
                ST_ARMED:  if (take) nxt = ST_SHIFT;
                ST_SHIFT:  if (src_ready && !src_valid) nxt = ST_STALL;
                ST_STALL:  if (take) nxt = ST_SHIFT;
                ST_REJECT: nxt = ST_REJECT;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // data path registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            cnt      <= '0;
            mode_q   <= LM_NONE;
            underrun <= 1'b0;
        end else if (cs_n) begin
            underrun <= 1'b0;
        end else begin
            if (state == ST_IDLE && cmd_load) begin
                mode_q   <= dec_mode;
                underrun <= 1'b0;
            end
            if (take) begin
                shreg <= src_data;
                cnt   <= slices_of(mode_q);
            end else if (sclk_fall && state == ST_SHIFT && cnt > CNT_W'(1)) begin
                shreg <= shreg_adv;
                cnt   <= cnt - CNT_W'(1);
            end
            if (src_ready && !src_valid) underrun <= 1'b1;
        end
    end

endmodule

// File: rtl/lane_read_shifter.sv
module lane_read_shifter
    import lrs_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk_fall,
    input  logic              cmd_load,
    input  logic [7:0]        cmd_opcode,
    input  logic              qe_bit,
    input  logic [BYTE_W-1:0] src_data,
    input  logic              src_valid,
    output logic              src_ready,
    output logic [LANES-1:0]  io_out,
    output logic [LANES-1:0]  io_oe,
    output logic              underrun
);

    lane_mode_e        dec_mode;
    lane_mode_e        mode_q;
    seq_state_e        seq_state;
    logic [BYTE_W-1:0] shreg;
    logic              drive;

    lrs_mode_dec #(.OP_W(8)) dec_i (
        .opcode (cmd_opcode),
        .qe     (qe_bit),
        .mode   (dec_mode)
    );

    lrs_seq #(.BYTE_W(BYTE_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk_fall (sclk_fall),
        .cmd_load  (cmd_load),
        .dec_mode  (dec_mode),
        .src_data  (src_data),
        .src_valid (src_valid),
        .src_ready (src_ready),
        .state     (seq_state),
        .mode_q    (mode_q),
        .shreg     (shreg),
        .drive     (drive),
        .underrun  (underrun)
    );

    lrs_lane_map #(.BYTE_W(BYTE_W), .LANES(LANES)) map_i (
        .mode   (mode_q),
        .drive  (drive),
        .shreg  (shreg),
        .io_out (io_out),
        .io_oe  (io_oe)
    );

endmodule

// File: rtl/lrs_checker.sv
module lrs_checker
    import lrs_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             sclk_fall,
    input logic             cmd_load,
    input logic             src_ready,
    input logic [LANES-1:0] io_out,
    input logic [LANES-1:0] io_oe,
    input logic             underrun,
    input seq_state_e       state
);

    p_release_on_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (io_oe == '0 && !underrun));

    p_lanes_hold_between_edges_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_fall && !cs_n && !cmd_load) |=> ($stable(io_out) && $stable(io_oe)));

    p_ready_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> (sclk_fall && !cs_n));

    p_reject_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REJECT) |-> (io_oe == '0 && !src_ready));

    p_underrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !cs_n) |=> underrun);

    p_armed_undriven_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED) |-> (io_oe == '0));

    always_comb begin
        if (rst_n) begin
            p_oe_legal_r4: assert (io_oe == 4'b0000 || io_oe == 4'b0010 ||
                                   io_oe == 4'b0011 || io_oe == 4'b1111);
            p_undriven_zero_r10: assert ((io_out & ~io_oe) == '0);
        end
    end

endmodule

bind lane_read_shifter lrs_checker #(.LANES(LANES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk_fall (sclk_fall),
    .cmd_load  (cmd_load),
    .src_ready (src_ready),
    .io_out    (io_out),
    .io_oe     (io_oe),
    .underrun  (underrun),
    .state     (seq_state)
);

// File: tb/lane_read_shifter_tb_top.sv
module lane_read_shifter_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk_fall = 1'b0;
    logic       cmd_load = 1'b0;
    logic [7:0] cmd_opcode = 8'h00;
    logic       qe_bit = 1'b0;
    logic [7:0] src_data;
    logic       src_valid;
    logic       src_ready;
    logic [3:0] io_out;
    logic [3:0] io_oe;
    logic       underrun;

    int checks = 0;
    int failures = 0;

    logic [7:0] src_mem [16];
    int         src_n = 0;
    int         src_idx = 0;
    logic       hold_src = 1'b0;

    logic [7:0] exp_q [$];
    int         mon_bpc = 0;
    logic [3:0] mon_oe = 4'b0000;
    string      mon_tag = "R2";
    logic       fall_q = 1'b0;
    logic       acc_q = 1'b0;
    int         slice_idx = 0;
    logic [7:0] acc_byte = 8'h00;
    logic       reject_bad = 1'b0;
    logic [3:0] prev_io = 4'b0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_read_shifter dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk_fall(sclk_fall),
        .cmd_load(cmd_load), .cmd_opcode(cmd_opcode), .qe_bit(qe_bit),
        .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
        .io_out(io_out), .io_oe(io_oe), .underrun(underrun)
    );

    assign src_valid = !cs_n && !hold_src && (src_idx < src_n);
    assign src_data  = src_mem[src_idx[3:0]];

    always @(posedge clk) begin
        fall_q <= sclk_fall;
        acc_q  <= src_ready && src_valid;
        if (cs_n) src_idx <= 0;
        else if (src_ready && src_valid) src_idx <= src_idx + 1;
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: reassembles bytes from the lanes and pops the scoreboard
    always @(negedge clk) begin
        if (cs_n) begin
            slice_idx = 0;
        end else begin
            if (mon_bpc == 0 && io_oe != 4'b0000) reject_bad = 1'b1;
            if (!fall_q && rst_n)
                check(io_out == prev_io, "R6 lanes moved without edge", int'(io_out), int'(prev_io));
            if (mon_bpc != 0 && fall_q && (slice_idx != 0 || acc_q)) begin
                case (mon_bpc)
                    1:       acc_byte = {acc_byte[6:0], io_out[1]};
                    2:       acc_byte = {acc_byte[5:0], io_out[1:0]};
                    default: acc_byte = {acc_byte[3:0], io_out[3:0]};
                endcase
                check(io_oe == mon_oe, {mon_tag, " lane enables"}, int'(io_oe), int'(mon_oe));
                slice_idx++;
                if (slice_idx == 8 / mon_bpc) begin
                    slice_idx = 0;
                    if (exp_q.size() == 0) begin
                        check(1'b0, {mon_tag, " unexpected byte"}, int'(acc_byte), 0);
                    end else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        check(acc_byte == e, {mon_tag, " byte"}, int'(acc_byte), int'(e));
                    end
                end
            end
        end
        prev_io = io_out;
    end

    function automatic int exp_bpc(input logic [7:0] op, input logic qe);
        case (op)
            8'h03, 8'h0B:        return 1;
            8'h3B, 8'hBB:        return 2;
            8'h6B, 8'hEB, 8'hE7: return qe ? 4 : 0;
            default:             return 0;
        endcase
    endfunction

    task automatic fall_n(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk) sclk_fall = 1'b1;
            @(negedge clk) sclk_fall = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic prep(input logic [7:0] op, input logic qe, input int n, input int seed);
        mon_bpc = exp_bpc(op, qe);
        case (mon_bpc)
            1:       begin mon_oe = 4'b0010; mon_tag = "R2"; end
            2:       begin mon_oe = 4'b0011; mon_tag = "R3"; end
            4:       begin mon_oe = 4'b1111; mon_tag = "R4"; end
            default: begin mon_oe = 4'b0000; mon_tag = "R5"; end
        endcase
        src_n = n;
        reject_bad = 1'b0;
        for (int i = 0; i < n; i++) begin
            src_mem[i] = 8'((seed * 37 + i * 91) ^ 8'h5A);
            if (mon_bpc != 0) exp_q.push_back(src_mem[i]);
        end
    endtask

    task automatic begin_cmd(input logic [7:0] op, input logic qe);
        @(negedge clk);
        cs_n = 1'b0; cmd_load = 1'b1; cmd_opcode = op; qe_bit = qe;
        @(negedge clk) cmd_load = 1'b0;
    endtask

    task automatic drain();
        while (src_idx < src_n) fall_n(1);
        fall_n(8 / mon_bpc - 1);
        check(exp_q.size() == 0, {mon_tag, " all bytes seen"}, exp_q.size(), 0);
    endtask

    task automatic end_cmd();
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
        check(io_oe == 4'b0000, "R10 enables after deselect", int'(io_oe), 0);
        check(underrun == 1'b0, "R10 underrun after deselect", int'(underrun), 0);
        exp_q.delete();
    endtask

    task automatic run_cmd(input logic [7:0] op, input logic qe, input int n, input int seed);
        prep(op, qe, n, seed);
        begin_cmd(op, qe);
        if (mon_bpc == 0) begin
            fall_n(6);
            check(src_idx == 0, "R5 no byte taken", src_idx, 0);
            check(reject_bad == 1'b0, "R5 lanes stayed released", int'(reject_bad), 0);
        end else begin
            drain();
            check(underrun == 1'b0, "R9 no underrun with steady source", int'(underrun), 0);
        end
        end_cmd();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(io_oe == 4'b0000, "R1 enables", int'(io_oe), 0);
        check(io_out == 4'b0000, "R1 lanes", int'(io_out), 0);
        check(underrun == 1'b0, "R1 underrun", int'(underrun), 0);

        // R2, R3, R4 with R7 pacing through the scoreboard
        run_cmd(8'h03, 1'b0, 3, 1);
        run_cmd(8'h0B, 1'b1, 2, 2);
        run_cmd(8'h3B, 1'b0, 4, 3);
        run_cmd(8'hBB, 1'b1, 3, 4);
        run_cmd(8'h6B, 1'b1, 5, 5);
        run_cmd(8'hEB, 1'b1, 4, 6);
        run_cmd(8'hE7, 1'b1, 6, 7);
        // R5 refused or unknown commands
        run_cmd(8'h6B, 1'b0, 3, 8);
        run_cmd(8'hEB, 1'b0, 3, 9);
        run_cmd(8'hE7, 1'b0, 3, 10);
        run_cmd(8'h9F, 1'b1, 3, 11);

        // R8: armed with empty source keeps lanes released, flags underrun
        prep(8'hEB, 1'b1, 3, 12);
        hold_src = 1'b1;
        begin_cmd(8'hEB, 1'b1);
        fall_n(2);
        check(io_oe == 4'b0000, "R8 lanes released before first byte", int'(io_oe), 0);
        check(underrun == 1'b1, "R9 underrun while armed", int'(underrun), 1);
        hold_src = 1'b0;
        drain();
        check(underrun == 1'b1, "R9 underrun sticky", int'(underrun), 1);
        end_cmd();

        // R9: mid-stream stall holds the last pair
        prep(8'h3B, 1'b0, 3, 13);
        begin_cmd(8'h3B, 1'b0);
        fall_n(1);
        hold_src = 1'b1;
        fall_n(6);
        check(io_out[1:0] == src_mem[0][1:0], "R9 held pair", int'(io_out[1:0]), int'(src_mem[0][1:0]));
        check(io_oe == 4'b0011, "R9 enables kept in stall", int'(io_oe), 3);
        check(underrun == 1'b1, "R9 underrun on stall", int'(underrun), 1);
        hold_src = 1'b0;
        drain();
        end_cmd();

        // R11: load mid-stream ignored
        prep(8'h03, 1'b0, 3, 14);
        begin_cmd(8'h03, 1'b0);
        fall_n(2);
        @(negedge clk) begin cmd_load = 1'b1; cmd_opcode = 8'h6B; qe_bit = 1'b1; end
        @(negedge clk) cmd_load = 1'b0;
        drain();
        end_cmd();

        // R11: load while deselected ignored
        prep(8'h3B, 1'b0, 2, 15);
        mon_bpc = 0;
        exp_q.delete();
        @(negedge clk) begin cmd_load = 1'b1; cmd_opcode = 8'h3B; end
        @(negedge clk) begin cmd_load = 1'b0; cs_n = 1'b0; end
        fall_n(3);
        check(io_oe == 4'b0000, "R11 no command after deselected load", int'(io_oe), 0);
        check(src_idx == 0, "R11 no byte taken", src_idx, 0);
        end_cmd();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule